// File: doc/BRIEF.md
# Segmented Base-Bound Address Translator

This block turns a virtual address into a physical address for a small memory management unit. The two top bits of the virtual address pick a segment: code, heap or stack. The bits below them are an offset into that segment. For a user-mode access, the block adds the offset to the segment's base register and checks the offset against the segment's bound register. If a check fails, the block reports a fault code instead of an address. A supervisor-mode access passes through unchanged, with no bounds check.

The base and bound pairs are changed through a single-pair write port, and only a supervisor-mode write takes effect. The whole register set is also always visible on a flat context bus, and a restore strobe loads it back in one cycle. This lets an operating system save and restore the set at a context switch. Requests and responses use valid/ready handshaking, and the response is registered.

Top module: `seg_xlate`

## Requirements
- R1: For a user-mode request, the selector is vaddr[VA_W-1:VA_W-2]: 00 is code, 01 is heap, 11 is stack. The offset is vaddr[VA_W-3:0]. The response address is the selected base plus the offset, taken modulo 2^PA_W, and the fault code is 00.
- R2: A user-mode request whose offset is greater than the selected bound gets fault code 01 and a response address of zero. An offset equal to the bound is translated normally.
- R3: A user-mode request with selector 10 gets fault code 11 and a response address of zero.
- R4: A supervisor-mode request (req_user = 0) returns vaddr zero-extended to PA_W, with fault code 00, for every selector and offset.
- R5: A supervisor-mode write (cfg_we = 1, cfg_user = 0) replaces the base and bound of the segment named by cfg_sel. The new values are used by requests accepted after that edge. A write with selector 10 changes nothing.
- R6: A user-mode write (cfg_we = 1, cfg_user = 1) leaves every register unchanged. In the following cycle, cfg_fault shows 10 (privilege). In all other cycles cfg_fault is 00.
- R7: ctx_out always shows the full register set. Slots are packed from the LSB in the order code, heap, stack, and each slot is {bound, base} with base in the low PA_W bits. A cycle with ctx_load = 1 loads ctx_in in that same layout, and it wins over any write in the same cycle.
- R8: A request is accepted when req_valid and req_ready are both 1, where req_ready = !rsp_valid || rsp_ready. Its response appears one cycle after acceptance. While rsp_ready is 0, the response is held unchanged.
- R9: After reset, rsp_valid is 0 and every base and bound is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | VA_W | Virtual address |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | PA_W | Physical address (zero on fault) |
| rsp_fault | output | 2 | 00 none, 01 bounds, 10 privilege, 11 unmapped |
| cfg_we | input | 1 | Write one base/bound pair |
| cfg_user | input | 1 | Mode of the writer, 1 = user |
| cfg_sel | input | 2 | Segment selector to write |
| cfg_base | input | PA_W | New base |
| cfg_bound | input | VA_W-2 | New bound (largest legal offset) |
| cfg_fault | output | 2 | 10 one cycle after a refused write, else 00 |
| ctx_load | input | 1 | Restore the whole set from ctx_in |
| ctx_in | input | 3*(PA_W+VA_W-2) | Set to restore |
| ctx_out | output | 3*(PA_W+VA_W-2) | Current set, for saving |

## Verification
The bench builds the translator with 12-bit virtual and 16-bit physical addresses, which gives 10-bit offsets. At this size, random bounds and offsets often land on or next to each other, so the equal-to-bound and one-past-bound cases come up naturally. Random bases near the top of the 16-bit range make base plus offset wrap. The 78-bit context bus is also small enough to compare whole against a model in the bench after every write and restore.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_BOUNDS = 2'b01,
        CAUSE_PRIV   = 2'b10,
        CAUSE_UNMAP  = 2'b11
    } cause_e;

    localparam int NUM_SLOTS = 3;

    localparam logic [1:0] SEL_CODE  = 2'b00;
    localparam logic [1:0] SEL_HEAP  = 2'b01;
    localparam logic [1:0] SEL_HOLE  = 2'b10;
    localparam logic [1:0] SEL_STACK = 2'b11;

    // storage slot for a mapped selector: code 0, heap 1, stack 2
    function automatic int sel_to_slot(logic [1:0] sel);
        return (sel == SEL_STACK) ? 2 : int'(sel);
    endfunction

endpackage

// File: rtl/seg_bank.sv
module seg_bank
    import seg_xlate_pkg::*;
#(
    parameter int PA_W  = 20,
    parameter int OFF_W = 14,
    localparam int EW    = PA_W + OFF_W,
    localparam int SET_W = NUM_SLOTS * EW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_user,
    input  logic [1:0]       cfg_sel,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [OFF_W-1:0] cfg_bound,
    input  logic             ctx_load,
    input  logic [SET_W-1:0] ctx_in,
    output logic [SET_W-1:0] set_o,
    output logic [1:0]       cfg_fault
);

    typedef struct packed {
        logic [SET_W-1:0] set;
        logic [1:0]       cfault;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d        = bank_q;
        bank_d.cfault = CAUSE_NONE;
        if (cfg_we && cfg_user) begin
            bank_d.cfault = CAUSE_PRIV;
        end
        if (ctx_load) begin
            bank_d.set = ctx_in;
        end else if (cfg_we && !cfg_user && cfg_sel != SEL_HOLE) begin
            bank_d.set[sel_to_slot(cfg_sel)*EW +: EW] = {cfg_bound, cfg_base};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign set_o     = bank_q.set;
    assign cfg_fault = bank_q.cfault;

endmodule

// File: rtl/seg_lookup.sv
module seg_lookup
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int PA_W  = 20,
    localparam int OFF_W = VA_W - 2,
    localparam int EW    = PA_W + OFF_W,
    localparam int SET_W = NUM_SLOTS * EW
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic             user,
    input  logic [SET_W-1:0] set_i,
    output logic [PA_W-1:0]  paddr,
    output logic [1:0]       cause
);

    logic [PA_W-1:0]  base_a  [4];
    logic [OFF_W-1:0] bound_a [4];

    for (genvar s = 0; s < 4; s++) begin : g_sel
        if (s == int'(SEL_HOLE)) begin : g_hole
            assign base_a[s]  = '0;
            assign bound_a[s] = '0;
        end else begin : g_map
            localparam int SLOT = sel_to_slot(2'(s));
            assign base_a[s]  = set_i[SLOT*EW +: PA_W];
            assign bound_a[s] = set_i[SLOT*EW + PA_W +: OFF_W];
        end
    end

    logic [1:0]       sel;
    logic [OFF_W-1:0] off;

    assign sel = vaddr[VA_W-1 -: 2];
    assign off = vaddr[OFF_W-1:0];

    always_comb begin
        paddr = '0;
        cause = CAUSE_NONE;
        if (!user) begin
            paddr = PA_W'(vaddr);
        end else if (sel == SEL_HOLE) begin
            cause = CAUSE_UNMAP;
        end else if (off > bound_a[sel]) begin
            cause = CAUSE_BOUNDS;
        end else begin
            paddr = base_a[sel] + PA_W'(off);
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int VA_W = 16,
    parameter int PA_W = 20
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [VA_W-1:0]                req_vaddr,
    input  logic                           req_user,
    output logic                           rsp_valid,
    input  logic                           rsp_ready,
    output logic [PA_W-1:0]                rsp_paddr,
    output logic [1:0]                     rsp_fault,
    input  logic                           cfg_we,
    input  logic                           cfg_user,
    input  logic [1:0]                     cfg_sel,
    input  logic [PA_W-1:0]                cfg_base,
    input  logic [VA_W-3:0]                cfg_bound,
    output logic [1:0]                     cfg_fault,
    input  logic                           ctx_load,
    input  logic [3*(PA_W+VA_W-2)-1:0]     ctx_in,
    output logic [3*(PA_W+VA_W-2)-1:0]     ctx_out
);

    localparam int OFF_W = VA_W - 2;

    logic [PA_W-1:0] xl_paddr;
    logic [1:0]      xl_cause;

    seg_bank #(.PA_W(PA_W), .OFF_W(OFF_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_user  (cfg_user),
        .cfg_sel   (cfg_sel),
        .cfg_base  (cfg_base),
        .cfg_bound (cfg_bound),
        .ctx_load  (ctx_load),
        .ctx_in    (ctx_in),
        .set_o     (ctx_out),
        .cfg_fault (cfg_fault)
    );

    seg_lookup #(.VA_W(VA_W), .PA_W(PA_W)) u_lookup (
        .vaddr (req_vaddr),
        .user  (req_user),
        .set_i (ctx_out),
        .paddr (xl_paddr),
        .cause (xl_cause)
    );

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        logic [1:0]      cause;
    } rsp_t;

    rsp_t rsp_d, rsp_q;
    logic accept;

    assign req_ready = !rsp_q.valid || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        rsp_d = rsp_q;
        if (accept) begin
            rsp_d.valid = 1'b1;
            rsp_d.paddr = xl_paddr;
            rsp_d.cause = xl_cause;
        end else if (rsp_ready) begin
            rsp_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_fault = rsp_q.cause;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int VA_W = 16,
    parameter int PA_W = 20
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [VA_W-1:0]            req_vaddr,
    input logic                       req_user,
    input logic                       rsp_valid,
    input logic                       rsp_ready,
    input logic [PA_W-1:0]            rsp_paddr,
    input logic [1:0]                 rsp_fault,
    input logic                       cfg_we,
    input logic                       cfg_user,
    input logic [1:0]                 cfg_fault,
    input logic                       ctx_load,
    input logic [3*(PA_W+VA_W-2)-1:0] ctx_out
);

    // R8: a stalled response keeps its contents
    p_hold_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

    // R2, R3: a faulting response carries no address
    p_fault_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 2'b00 |-> rsp_paddr == '0);

    // R3: selector 10 in user mode is unmapped
    p_unmapped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_user && req_vaddr[VA_W-1 -: 2] == 2'b10
        |=> rsp_fault == 2'b11);

    // R4: supervisor access passes through
    p_passthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_user
        |=> rsp_fault == 2'b00 && rsp_paddr == PA_W'($past(req_vaddr)));

    // R6: a user-mode write changes nothing and is flagged
    p_priv_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_user && !ctx_load |=> $stable(ctx_out) && cfg_fault == 2'b10);

    // R6: no flag without a refused write
    p_no_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_user) |=> cfg_fault == 2'b00);

    // R8: a response appears after every accepted request
    p_rsp_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid);

endmodule

bind seg_xlate seg_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .req_user  (req_user),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .cfg_we    (cfg_we),
    .cfg_user  (cfg_user),
    .cfg_fault (cfg_fault),
    .ctx_load  (ctx_load),
    .ctx_out   (ctx_out)
);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;

    localparam int VA_W  = 12;
    localparam int PA_W  = 16;
    localparam int OFF_W = VA_W - 2;
    localparam int EW    = PA_W + OFF_W;
    localparam int SET_W = 3 * EW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_user = 1'b0, rsp_ready = 1'b1;
    logic [VA_W-1:0] req_vaddr = '0;
    logic req_ready, rsp_valid;
    logic [PA_W-1:0] rsp_paddr;
    logic [1:0] rsp_fault, cfg_fault;
    logic cfg_we = 1'b0, cfg_user = 1'b0, ctx_load = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [PA_W-1:0] cfg_base = '0;
    logic [OFF_W-1:0] cfg_bound = '0;
    logic [SET_W-1:0] ctx_in = '0, ctx_out;

    always #5 clk = ~clk;

    seg_xlate #(.VA_W(VA_W), .PA_W(PA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .cfg_we(cfg_we), .cfg_user(cfg_user), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
        .cfg_bound(cfg_bound), .cfg_fault(cfg_fault),
        .ctx_load(ctx_load), .ctx_in(ctx_in), .ctx_out(ctx_out)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [PA_W-1:0]  m_base  [3];
    logic [OFF_W-1:0] m_bound [3];

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int slot_of(input logic [1:0] sel);
        return (sel == 2'b11) ? 2 : int'(sel);
    endfunction

    function automatic logic [SET_W-1:0] model_set();
        logic [SET_W-1:0] v;
        for (int s = 0; s < 3; s++) v[s*EW +: EW] = {m_bound[s], m_base[s]};
        return v;
    endfunction

    task automatic exp_xlate(input logic [VA_W-1:0] va, input logic user,
                             output logic [PA_W-1:0] pa, output logic [1:0] fc);
        logic [1:0] sel = va[VA_W-1 -: 2];
        logic [OFF_W-1:0] off = va[OFF_W-1:0];
        pa = '0; fc = 2'b00;
        if (!user) pa = PA_W'(va);
        else if (sel == 2'b10) fc = 2'b11;
        else if (off > m_bound[slot_of(sel)]) fc = 2'b01;
        else pa = m_base[slot_of(sel)] + PA_W'(off);
    endtask

    task automatic do_req(input logic [VA_W-1:0] va, input logic user, input string req);
        logic [PA_W-1:0] pa;
        logic [1:0] fc;
        @(negedge clk);
        req_vaddr = va; req_user = user; req_valid = 1'b1; rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        exp_xlate(va, user, pa, fc);
        chk(rsp_valid == 1'b1, {req, " R8 valid"}, 128'(rsp_valid), 128'(1));
        chk(rsp_fault == fc && rsp_paddr == pa, req, 128'({rsp_fault, rsp_paddr}), 128'({fc, pa}));
    endtask

    task automatic do_cfg(input logic user, input logic [1:0] sel,
                          input logic [PA_W-1:0] b, input logic [OFF_W-1:0] bd, input string req);
        @(negedge clk);
        cfg_we = 1'b1; cfg_user = user; cfg_sel = sel; cfg_base = b; cfg_bound = bd;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!user && sel != 2'b10) begin
            m_base[slot_of(sel)] = b; m_bound[slot_of(sel)] = bd;
        end
        chk(cfg_fault == (user ? 2'b10 : 2'b00), {req, " cfg_fault"}, 128'(cfg_fault), 128'(user ? 2 : 0));
        chk(ctx_out == model_set(), {req, " ctx_out"}, 128'(ctx_out), 128'(model_set()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [VA_W-1:0] va_a, va_b;
        logic [PA_W-1:0] pa;
        logic [1:0] fc;
        int seed;
        seed = 7;
        void'($urandom(seed));
        for (int s = 0; s < 3; s++) begin m_base[s] = '0; m_bound[s] = '0; end
        repeat (2) @(negedge clk);
        // R9 reset state
        chk(rsp_valid == 1'b0, "R9 rsp_valid", 128'(rsp_valid), 128'(0));
        chk(ctx_out == '0, "R9 ctx_out", 128'(ctx_out), 128'(0));
        rst_n = 1'b1;
        do_req(12'h000, 1'b1, "R9 zero base offset 0");
        do_req(12'h001, 1'b1, "R2 zero bound offset 1");

        // R5 directed writes, R1 each segment
        do_cfg(1'b0, 2'b00, 16'h1000, 10'h0ff, "R5 code");
        do_cfg(1'b0, 2'b01, 16'h4000, 10'h3ff, "R5 heap");
        do_cfg(1'b0, 2'b11, 16'hfff0, 10'h020, "R5 stack");
        do_cfg(1'b0, 2'b10, 16'h1234, 10'h111, "R5 hole write ignored");
        do_req(12'h010, 1'b1, "R1 code");
        do_req(12'h5ab, 1'b1, "R1 heap");
        do_req(12'hc1f, 1'b1, "R1 stack wrap");
        // R2 boundary
        do_req(12'h0ff, 1'b1, "R2 offset equals bound");
        do_req(12'h100, 1'b1, "R2 offset one past bound");
        // R3, R4
        do_req(12'h800, 1'b1, "R3 unmapped");
        do_req(12'h9ff, 1'b0, "R4 supervisor hole");
        do_req(12'h3ff, 1'b0, "R4 supervisor past bound");
        // R6 refused write
        do_cfg(1'b1, 2'b00, 16'hbeef, 10'h3ff, "R6 user write");
        do_req(12'h100, 1'b1, "R6 bound unchanged after refused write");

        // R7 restore wins over a same-cycle write
        @(negedge clk);
        ctx_in = {$urandom, $urandom, $urandom};
        ctx_load = 1'b1; cfg_we = 1'b1; cfg_user = 1'b0; cfg_sel = 2'b00; cfg_base = 16'h0; cfg_bound = '0;
        @(negedge clk);
        ctx_load = 1'b0; cfg_we = 1'b0;
        for (int s = 0; s < 3; s++) begin
            m_base[s]  = ctx_in[s*EW +: PA_W];
            m_bound[s] = ctx_in[s*EW + PA_W +: OFF_W];
        end
        chk(ctx_out == ctx_in, "R7 restore", 128'(ctx_out), 128'(ctx_in));
        do_req({2'b01, m_bound[1]}, 1'b1, "R7 restored heap at bound");
        do_req({2'b11, OFF_W'(0)}, 1'b1, "R7 restored stack");

        // R8 back-pressure
        va_a = 12'h405; va_b = 12'h006;
        @(negedge clk);
        req_vaddr = va_a; req_user = 1'b1; req_valid = 1'b1; rsp_ready = 1'b0;
        @(negedge clk);
        exp_xlate(va_a, 1'b1, pa, fc);
        chk(rsp_valid && rsp_paddr == pa && rsp_fault == fc, "R8 first rsp", 128'({rsp_fault, rsp_paddr}), 128'({fc, pa}));
        chk(req_ready == 1'b0, "R8 ready low when stalled", 128'(req_ready), 128'(0));
        req_vaddr = va_b;
        @(negedge clk);
        chk(rsp_valid && rsp_paddr == pa && rsp_fault == fc, "R8 held", 128'({rsp_fault, rsp_paddr}), 128'({fc, pa}));
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        exp_xlate(va_b, 1'b1, pa, fc);
        chk(rsp_valid && rsp_paddr == pa && rsp_fault == fc, "R8 second rsp", 128'({rsp_fault, rsp_paddr}), 128'({fc, pa}));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 drained", 128'(rsp_valid), 128'(0));

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 9);
            if (op < 2) begin
                do_cfg(1'b0, 2'($urandom), 16'($urandom), 10'($urandom), "R5 random write");
            end else if (op == 2) begin
                do_cfg(1'b1, 2'($urandom), 16'($urandom), 10'($urandom), "R6 random user write");
            end else begin
                logic [1:0] sel = 2'($urandom);
                logic [OFF_W-1:0] off;
                if (op < 6 && sel != 2'b10) off = m_bound[slot_of(sel)] + 10'($urandom_range(0, 2)) - 10'd1;
                else off = 10'($urandom);
                do_req({sel, off}, ($urandom_range(0, 3) != 0), "R1 R2 R3 R4 random request");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule